// File: doc/BRIEF.md
# DRAM Input Address Normalizer

This block takes a 40-bit system physical address and produces the normalized input address that one memory node uses for its chip-select compare. It checks whether the address belongs to the node, lowers it by the hole size when memory has been hoisted above 4 GiB, and subtracts the node base. It also removes a 1, 2 or 3 bit node-interleave field that sits just above the 4 KiB page offset, so that the remaining bits of the address become contiguous.

A request is one cycle with `req_valid` high, with the address and the node configuration presented alongside it. On the next clock edge the block registers a hit flag, a 2-bit error code and the normalized address, and raises `rsp_done` for one cycle. Requests may come on consecutive cycles. The control is a two-state machine. `ST_IDLE` means that no response is pending. `ST_RESP` means that a result is on the outputs. The transition is taken on any clock edge that samples `req_valid`: it leads to `ST_RESP` when `req_valid` is high, or to `ST_IDLE` when it is low, whatever the current state. Matching chip-selects and choosing a DIMM happen downstream of this block.

Top module: `dram_addr_norm`

## Requirements
- R1: While `rst_n` is low, `rsp_done`, `rsp_hit`, `rsp_err` and `rsp_addr` are all zero.
- R2: `rsp_done` is high in exactly the cycle after each cycle in which `req_valid` was sampled high, and in no other cycle. Back-to-back requests give back-to-back responses, in order.
- R3: When the node base equals the node limit, every request returns error code 1 (no address) with `rsp_hit` low.
- R4: The range check uses the unmodified request address. An address equal to the base or equal to the limit is in range. An address below the base or above the limit returns code 1.
- R5: When the hole size is nonzero and the address is 0x1_0000_0000 or higher, the hole size is subtracted from the address before every later step. Below that bound, or with a hole size of zero, the address is used as it is.
- R6: The DRAM address is the adjusted address minus the base with base bits [23:0] forced to zero.
- R7: In range, an interleave enable of 2, 4, 5 or 6 returns error code 2 (bad configuration).
- R8: With a legal nonzero enable, adjusted address bits [14:12] ANDed with the enable must equal the interleave select. Otherwise the result is code 1.
- R9: On a hit, `rsp_addr` = {DRAM address bits [35+n:12+n], DRAM address bits [11:0]}, where n = 0, 1, 2 or 3 for the enables 0, 1, 3 and 7.
- R10: Error codes are 0 = ok, 1 = no address and 2 = bad configuration, and 3 never occurs. `rsp_hit` is high exactly when the code is 0. A range failure takes priority over a bad configuration, and a bad configuration takes priority over a select mismatch. `rsp_addr` is zero whenever `rsp_hit` is low.
- R11: In any cycle where `rsp_done` is low, `rsp_hit`, `rsp_err` and `rsp_addr` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, one cycle per request |
| req_addr | input | 40 | System physical address |
| cfg_base | input | 40 | Node base address (inclusive) |
| cfg_limit | input | 40 | Node limit address (inclusive) |
| cfg_ilv_en | input | 3 | Interleave enable mask: 0, 1, 3 or 7 |
| cfg_ilv_sel | input | 3 | Interleave select value for this node |
| cfg_hole_size | input | 40 | Memory hole size, 0 when no hoisting |
| rsp_done | output | 1 | One-cycle response pulse |
| rsp_hit | output | 1 | Address belongs to the node |
| rsp_err | output | 2 | 0 ok, 1 no address, 2 bad configuration |
| rsp_addr | output | 36 | Normalized input address |

## Verification
The assertions check the following on every cycle: the response timing of the handshake, zero outputs outside a response, agreement between the hit flag and the error code, the absence of code 3, and the no-address and bad-configuration results for an empty node, an out-of-range address and an illegal enable. The page offset passing through unchanged when there is no hole is also checked on every cycle. The hole subtraction near the 4 GiB bound, the masking of the base's low bits, the extraction of the shifted field for each interleave width, and the exact ordering of back-to-back results can only be shown by the bench scenarios. Those scenarios compare each result against an independently computed expected value.

// File: rtl/norm_pkg.sv
package norm_pkg;

    typedef enum logic [1:0] {
        ERR_NONE   = 2'd0,
        ERR_NOADDR = 2'd1,
        ERR_BADCFG = 2'd2
    } norm_err_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RESP = 1'b1
    } norm_state_e;

endpackage

// File: rtl/norm_window.sv
// Range check, hole correction and base subtraction.
module norm_window #(
    parameter int ADDR_W   = 40,
    parameter int HOLE_BIT = 32,
    parameter int BASE_LSB = 24
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [ADDR_W-1:0] base_i,
    input  logic [ADDR_W-1:0] limit_i,
    input  logic [ADDR_W-1:0] hole_i,
    output logic              miss_o,
    output logic [ADDR_W-1:0] adj_o,
    output logic [ADDR_W-1:0] dram_o
);

    logic              empty_node;
    logic              below_base;
    logic              above_limit;
    logic              high_region;
    logic [ADDR_W-1:0] base_kept;

    always_comb begin
        empty_node  = (base_i == limit_i);
        below_base  = (addr_i < base_i);
        above_limit = (addr_i > limit_i);
        miss_o      = empty_node | below_base | above_limit;

        high_region = |addr_i[ADDR_W-1:HOLE_BIT];
        if ((hole_i != '0) && high_region)
            adj_o = addr_i - hole_i;
        else
            adj_o = addr_i;

        base_kept = {base_i[ADDR_W-1:BASE_LSB], {BASE_LSB{1'b0}}};
        dram_o    = adj_o - base_kept;
    end

endmodule

// File: rtl/norm_ilv_strip.sv
// Interleave decode and removal of the interleave field.
module norm_ilv_strip #(
    parameter int ADDR_W   = 40,
    parameter int ILV_W    = 3,
    parameter int PAGE_LSB = 12,
    parameter int NORM_W   = 36
) (
    input  logic [ADDR_W-1:0] adj_i,
    input  logic [ADDR_W-1:0] dram_i,
    input  logic [ILV_W-1:0]  en_i,
    input  logic [ILV_W-1:0]  sel_i,
    output logic              cfg_bad_o,
    output logic              sel_miss_o,
    output logic [NORM_W-1:0] norm_o
);

    localparam int UPPER_W = NORM_W - PAGE_LSB;
    localparam int NVAR    = ILV_W + 1;
    localparam int TOP_USE = PAGE_LSB + ILV_W + UPPER_W;

    logic [NVAR-1:0]   way_hit;
    logic [NORM_W-1:0] variant [NVAR];
    logic [ILV_W-1:0]  node_bits;

    generate
        for (genvar k = 0; k < NVAR; k++) begin : g_way
            localparam logic [ILV_W-1:0] WAY_MASK = ILV_W'((1 << k) - 1);
            assign way_hit[k] = (en_i == WAY_MASK);
            assign variant[k] = {dram_i[PAGE_LSB+k +: UPPER_W], dram_i[PAGE_LSB-1:0]};
        end
    endgenerate

    assign node_bits = adj_i[PAGE_LSB +: ILV_W];

    always_comb begin
        cfg_bad_o  = ~(|way_hit);
        sel_miss_o = (en_i != '0) && ((node_bits & en_i) != sel_i);
        norm_o     = '0;
        for (int k = 0; k < NVAR; k++) begin
            if (way_hit[k])
                norm_o = norm_o | variant[k];
        end
    end

    logic unused_bits;
    assign unused_bits = ^{adj_i[ADDR_W-1:PAGE_LSB+ILV_W], adj_i[PAGE_LSB-1:0],
                           dram_i[ADDR_W-1:TOP_USE]};

endmodule

// File: rtl/dram_addr_norm.sv
module dram_addr_norm
    import norm_pkg::*;
#(
    parameter int ADDR_W   = 40,
    parameter int ILV_W    = 3,
    parameter int PAGE_LSB = 12,
    parameter int BASE_LSB = 24,
    parameter int HOLE_BIT = 32,
    parameter int NORM_W   = 36
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [ADDR_W-1:0] cfg_base,
    input  logic [ADDR_W-1:0] cfg_limit,
    input  logic [ILV_W-1:0]  cfg_ilv_en,
    input  logic [ILV_W-1:0]  cfg_ilv_sel,
    input  logic [ADDR_W-1:0] cfg_hole_size,
    output logic              rsp_done,
    output logic              rsp_hit,
    output logic [1:0]        rsp_err,
    output logic [NORM_W-1:0] rsp_addr
);

    logic              win_miss;
    logic [ADDR_W-1:0] adj_addr;
    logic [ADDR_W-1:0] dram_addr;
    logic              cfg_bad;
    logic              sel_miss;
    logic [NORM_W-1:0] norm_addr;
    norm_err_e         nxt_err;
    norm_state_e       state_q;
    norm_state_e       state_d;
    norm_err_e         err_q;
    logic              hit_q;
    logic [NORM_W-1:0] addr_q;

    norm_window #(
        .ADDR_W  (ADDR_W),
        .HOLE_BIT(HOLE_BIT),
        .BASE_LSB(BASE_LSB)
    ) window_i (
        .addr_i (req_addr),
        .base_i (cfg_base),
        .limit_i(cfg_limit),
        .hole_i (cfg_hole_size),
        .miss_o (win_miss),
        .adj_o  (adj_addr),
        .dram_o (dram_addr)
    );

    norm_ilv_strip #(
        .ADDR_W  (ADDR_W),
        .ILV_W   (ILV_W),
        .PAGE_LSB(PAGE_LSB),
        .NORM_W  (NORM_W)
    ) strip_i (
        .adj_i     (adj_addr),
        .dram_i    (dram_addr),
        .en_i      (cfg_ilv_en),
        .sel_i     (cfg_ilv_sel),
        .cfg_bad_o (cfg_bad),
        .sel_miss_o(sel_miss),
        .norm_o    (norm_addr)
    );

    // Priority: range, then configuration, then interleave select.
    always_comb begin
        if (win_miss)
            nxt_err = ERR_NOADDR;
        else if (cfg_bad)
            nxt_err = ERR_BADCFG;
        else if (sel_miss)
            nxt_err = ERR_NOADDR;
        else
            nxt_err = ERR_NONE;
    end

    always_comb begin
        state_d = req_valid ? ST_RESP : ST_IDLE;
    end

    // State register together with the captured result.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            err_q   <= ERR_NONE;
            hit_q   <= 1'b0;
            addr_q  <= '0;
        end else begin
            state_q <= state_d;
            if (req_valid) begin
                err_q  <= nxt_err;
                hit_q  <= (nxt_err == ERR_NONE);
                addr_q <= (nxt_err == ERR_NONE) ? norm_addr : '0;
            end else begin
                err_q  <= ERR_NONE;
                hit_q  <= 1'b0;
                addr_q <= '0;
            end
        end
    end

    // Output decode from the state.
    always_comb begin
        rsp_done = 1'b0;
        rsp_hit  = 1'b0;
        rsp_err  = 2'd0;
        rsp_addr = '0;
        unique case (state_q)
            ST_IDLE: begin
                rsp_done = 1'b0;
            end
            ST_RESP: begin
                rsp_done = 1'b1;
                rsp_hit  = hit_q;
                rsp_err  = err_q;
                rsp_addr = addr_q;
            end
        endcase
    end

endmodule

// File: rtl/norm_checker.sv
module norm_checker #(
    parameter int ADDR_W   = 40,
    parameter int ILV_W    = 3,
    parameter int PAGE_LSB = 12,
    parameter int NORM_W   = 36
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic [ADDR_W-1:0] req_addr,
    input logic [ADDR_W-1:0] cfg_base,
    input logic [ADDR_W-1:0] cfg_limit,
    input logic [ILV_W-1:0]  cfg_ilv_en,
    input logic [ADDR_W-1:0] cfg_hole_size,
    input logic              rsp_done,
    input logic              rsp_hit,
    input logic [1:0]        rsp_err,
    input logic [NORM_W-1:0] rsp_addr
);

    always_comb begin
        if (!rst_n) begin
            AST_RESET_QUIET: assert (!rsp_done && !rsp_hit && rsp_err == 2'd0 && rsp_addr == '0); // R1
        end
    end

    AST_DONE_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_done); // R2
    AST_NO_SPURIOUS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_done); // R2
    AST_EMPTY_NODE: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && cfg_base == cfg_limit) |=> (rsp_err == 2'd1 && !rsp_hit)); // R3
    AST_OUT_OF_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && (req_addr < cfg_base || req_addr > cfg_limit)) |=> (rsp_err == 2'd1)); // R4
    AST_BAD_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && cfg_base != cfg_limit && req_addr >= cfg_base && req_addr <= cfg_limit
         && (cfg_ilv_en == 3'd2 || cfg_ilv_en == 3'd4 || cfg_ilv_en == 3'd5 || cfg_ilv_en == 3'd6))
        |=> (rsp_err == 2'd2)); // R7
    AST_OFFSET_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && cfg_hole_size == '0)
        |=> (!rsp_hit || rsp_addr[PAGE_LSB-1:0] == $past(req_addr[PAGE_LSB-1:0]))); // R9
    AST_HIT_MATCHES_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |-> (rsp_hit == (rsp_err == 2'd0))); // R10
    AST_NO_CODE_THREE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_err != 2'd3); // R10
    AST_MISS_ZERO_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_hit |-> (rsp_addr == '0)); // R10
    AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_done |-> (!rsp_hit && rsp_err == 2'd0)); // R11

endmodule

bind dram_addr_norm norm_checker #(
    .ADDR_W  (ADDR_W),
    .ILV_W   (ILV_W),
    .PAGE_LSB(PAGE_LSB),
    .NORM_W  (NORM_W)
) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .req_addr     (req_addr),
    .cfg_base     (cfg_base),
    .cfg_limit    (cfg_limit),
    .cfg_ilv_en   (cfg_ilv_en),
    .cfg_hole_size(cfg_hole_size),
    .rsp_done     (rsp_done),
    .rsp_hit      (rsp_hit),
    .rsp_err      (rsp_err),
    .rsp_addr     (rsp_addr)
);

// File: tb/dram_addr_norm_tb_top.sv
module dram_addr_norm_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam longint M40 = 64'hFF_FFFF_FFFF;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [39:0] req_addr = '0;
    logic [39:0] cfg_base = '0;
    logic [39:0] cfg_limit = '0;
    logic [2:0]  cfg_ilv_en = '0;
    logic [2:0]  cfg_ilv_sel = '0;
    logic [39:0] cfg_hole_size = '0;
    logic        rsp_done;
    logic        rsp_hit;
    logic [1:0]  rsp_err;
    logic [35:0] rsp_addr;

    int n_checks = 0;
    int n_fail = 0;
    bit running = 1'b0;

    typedef struct {
        longint addr;
        bit     hit;
        int     err;
        string  tag;
    } exp_t;

    exp_t sb[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    dram_addr_norm dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_valid    (req_valid),
        .req_addr     (req_addr),
        .cfg_base     (cfg_base),
        .cfg_limit    (cfg_limit),
        .cfg_ilv_en   (cfg_ilv_en),
        .cfg_ilv_sel  (cfg_ilv_sel),
        .cfg_hole_size(cfg_hole_size),
        .rsp_done     (rsp_done),
        .rsp_hit      (rsp_hit),
        .rsp_err      (rsp_err),
        .rsp_addr     (rsp_addr)
    );

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    // Reference model written from the requirements.
    function automatic exp_t model(longint a, longint b, longint l, int en, int sel, longint h, string tag);
        exp_t e;
        longint adj;
        longint d;
        int n;
        e.tag = tag; e.hit = 0; e.addr = 0; e.err = 1;
        if (b == l || a < b || a > l) return e;
        adj = a;
        if (h != 0 && a >= 64'h1_0000_0000) adj = (a - h) & M40;
        d = (adj - (b & 64'hFF_FF00_0000)) & M40;
        n = 0;
        if (en != 0) begin
            if (en == 1) n = 1;
            else if (en == 3) n = 2;
            else if (en == 7) n = 3;
            else begin e.err = 2; return e; end
            if ((((adj >> 12) & 7) & en) != sel) return e;
        end
        e.err = 0; e.hit = 1;
        e.addr = (((d >> (12 + n)) & 64'hFF_FFFF) << 12) | (d & 64'hFFF);
        return e;
    endfunction

    task automatic send(longint a, longint b, longint l, int en, int sel, longint h, string tag);
        @(negedge clk);
        req_valid = 1'b1;
        req_addr = a[39:0]; cfg_base = b[39:0]; cfg_limit = l[39:0];
        cfg_ilv_en = en[2:0]; cfg_ilv_sel = sel[2:0]; cfg_hole_size = h[39:0];
        sb.push_back(model(a, b, l, en, sel, h, tag));
    endtask

    task automatic idle(int cycles);
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            req_valid = 1'b0;
        end
    endtask

    // Monitor: pops the oldest expected item on each response.
    always @(negedge clk) begin
        if (running && rst_n) begin
            if (rsp_done) begin
                if (sb.size() == 0) begin
                    check(1'b0, "R2 unexpected response", 1, 0);
                end else begin
                    exp_t e;
                    e = sb.pop_front();
                    check(rsp_hit == e.hit, {e.tag, " hit"}, longint'(rsp_hit), longint'(e.hit));
                    check(int'(rsp_err) == e.err, {e.tag, " code"}, longint'(rsp_err), longint'(e.err));
                    check(longint'(rsp_addr) == e.addr, {e.tag, " addr"}, longint'(rsp_addr), e.addr);
                end
            end else begin
                check(!rsp_hit && rsp_err == 2'd0 && rsp_addr == '0, "R11 idle outputs",
                      longint'({rsp_hit, rsp_err, rsp_addr}), 0);
            end
        end
    end

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin : stim
        repeat (3) @(negedge clk);
        check(!rsp_done && !rsp_hit && rsp_err == 2'd0 && rsp_addr == '0, "R1 reset outputs",
              longint'({rsp_done, rsp_hit, rsp_err, rsp_addr}), 0);
        rst_n = 1'b1;
        running = 1'b1;
        idle(2);

        // R9 plain translation, no interleave
        send(64'h0_1234_5678, 0, 64'h3_FFFF_FFFF, 0, 0, 0, "R9 plain");
        // R6 base low bits ignored in subtraction
        send(64'h2_0400_1ABC, 64'h2_0312_3456, 64'h3_FFFF_FFFF, 0, 0, 0, "R6 base mask");
        // R4 inclusive edges
        send(64'h2_0312_3456, 64'h2_0312_3456, 64'h3_FFFF_FFFF, 0, 0, 0, "R4 at base");
        send(64'h3_FFFF_FFFF, 64'h2_0312_3456, 64'h3_FFFF_FFFF, 0, 0, 0, "R4 at limit");
        send(64'h2_0312_3455, 64'h2_0312_3456, 64'h3_FFFF_FFFF, 0, 0, 0, "R4 below base");
        send(64'h4_0000_0000, 64'h2_0312_3456, 64'h3_FFFF_FFFF, 0, 0, 0, "R4 above limit");
        // R3 empty node
        send(64'h1_0000_0000, 64'h1_0000_0000, 64'h1_0000_0000, 0, 0, 0, "R3 empty node");
        send(0, 0, 0, 0, 0, 0, "R3 empty zero");
        // R5 hole around 4 GiB
        send(64'h1_0000_0000, 0, 64'h4_FFFF_FFFF, 0, 0, 64'h4000_0000, "R5 hole at 4G");
        send(64'h0_FFFF_FFFF, 0, 64'h4_FFFF_FFFF, 0, 0, 64'h4000_0000, "R5 below 4G");
        send(64'h3_8765_4321, 0, 64'h4_FFFF_FFFF, 0, 0, 0, "R5 zero hole");
        // R8 / R9 interleave
        send(64'h0_ABCD_1FFF, 0, 64'hF_FFFF_FFFF, 1, 1, 0, "R9 two-way");
        send(64'h0_ABCD_0FFF, 0, 64'hF_FFFF_FFFF, 1, 1, 0, "R8 two-way miss");
        send(64'h5_1234_6ABC, 64'h1_0000_0000, 64'hF_FFFF_FFFF, 3, 2, 0, "R9 four-way");
        send(64'h5_1234_7ABC, 64'h1_0000_0000, 64'hF_FFFF_FFFF, 3, 2, 0, "R8 four-way miss");
        send(64'h7_FEDC_DABC, 64'h1_0000_0000, 64'hF_FFFF_FFFF, 7, 5, 0, "R9 eight-way");
        send(64'h1_4000_3000, 0, 64'hF_FFFF_FFFF, 3, 3, 64'h4000_0000, "R8 select after hole");
        // R7 / R10 bad enable and priority
        send(64'h0_1000_0000, 0, 64'h3_FFFF_FFFF, 2, 0, 0, "R7 enable 2");
        send(64'h0_1000_0000, 0, 64'h3_FFFF_FFFF, 5, 0, 0, "R7 enable 5");
        send(64'h9_0000_0000, 0, 64'h3_FFFF_FFFF, 6, 0, 0, "R10 range over config");
        send(64'h0_1000_0000, 0, 64'h3_FFFF_FFFF, 4, 1, 0, "R10 config over select");
        idle(3);

        // R2 back-to-back mixed burst
        for (int i = 0; i < 60; i++) begin
            longint b, l, a, h;
            int en, sel, pick;
            b = {24'd0, 8'($urandom_range(0, 127)), $urandom} & M40;
            l = b + {32'd0, $urandom};
            a = b + {32'd0, $urandom} - 64'h1000_0000;
            if (a < 0) a = 0;
            h = ($urandom_range(0, 1) == 1) ? longint'({$urandom_range(1, 255), 24'd0}) : 0;
            pick = $urandom_range(0, 5);
            en = (pick == 0) ? 0 : (pick == 1) ? 1 : (pick == 2) ? 3 : (pick == 3) ? 7 : pick;
            sel = $urandom_range(0, 7) & en;
            send(a & M40, b, l & M40, en, sel, h, "R2 burst");
        end
        idle(4);
        check(sb.size() == 0, "R2 all responses seen", longint'(sb.size()), 0);

        running = 1'b0;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule